// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This block is a watchdog peripheral with a small register interface. Software sets a reload value, a window delta, a reset-enable bit and a disable bit in a mode register. It then restarts the counter at intervals through a keyed command in the control register. A 12-bit down-counter steps once every `DIV` pulses of a slow-clock enable. With the default `DIV` of 128 and a 32768 Hz enable, the counter steps at 256 Hz, so the largest reload of 0xFFF gives a 16 s timeout. If the counter runs out, or software restarts too early (while the count is still above the window delta), the block records the event in a status register and can raise a one-cycle reset request.

A restart takes effect in the slow domain. The reload is applied on the next slow-clock pulse and reloads the counter even when it had stopped at zero. For three slow-clock periods after a restart, mode writes are refused and flagged. A lock command freezes the mode register until the next hardware reset.

Top module: `lockwd_top`

## Requirements
- R1: After reset the status register (address 2) reads 0 and the mode register (address 1) reads 0x10FFFFFF. Mode fields: reload in bits [11:0], delta in bits [23:12], reset-enable in bit 28, disable in bit 29.
- R2: A write to the control register (address 0) with bit 0 set restarts the counter only when bits [31:24] equal the key 0xA5. A write with any other key changes nothing.
- R3: A restart is applied on the next slow-clock pulse, which loads the reload value (including after a stop at zero) and clears the prescaler. The counter then decrements on every `DIV`-th slow pulse. The underflow falls on slow pulse (reload+1)*`DIV` after the one that applied the reload.
- R4: An underflow sets status bit 0 and, when reset-enable is 1, gives one reset-request pulse. The counter then stays stopped with no further events until the next restart.
- R5: A restart while the counter is strictly above the delta sets status bit 1 and, when reset-enable is 1, gives one reset-request pulse. A restart at a count equal to the delta is not an error.
- R6: A write to the control register with bit 1 set locks the mode register. Later mode writes have no effect until a hardware reset, which clears the lock.
- R7: For `HOLD` (3) slow pulses after a restart, mode writes are dropped and set the sticky status bit 2. The write after the third slow pulse is accepted.
- R8: Reading the status register clears all of its bits.
- R9: With the disable bit set the counter does not step and no reset request is raised.
- R10: The reset request is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus/system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable at the slow-clock rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after rd_en |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The timeout path is swept over reload values 0 to 6. The sweep separates an off-by-one in the prescaler or in the zero step, and it also shows that a stopped counter reloads from a new value. Restarts are placed at counts 5, 4, 3 and 2 against a delta of 3, which separates a strict from a non-strict window compare. Mode writes are tried two, one and zero slow pulses before the hold-off ends, and again after a lock and after a reset. Wrong keys, the disable bit and a cleared reset-enable each show no pulse where the enabled case shows one.

// File: rtl/lockwd_pkg.sv
// Package: shared register map, field positions and the mode record type.
// Assumes a 32-bit data path and a 2-bit register address.
package lockwd_pkg;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    // Control register fields
    localparam int C_RESTART = 0;
    localparam int C_LOCK    = 1;
    localparam int C_KEY_LSB = 24;

    // Mode register fields
    localparam int M_RELOAD_LSB = 0;
    localparam int M_DELTA_LSB  = 12;
    localparam int M_RSTEN      = 28;
    localparam int M_DIS        = 29;

    // Status register fields
    localparam int S_UF  = 0;
    localparam int S_WE  = 1;
    localparam int S_REJ = 2;

    typedef struct packed {
        logic             dis;
        logic             rst_en;
        logic [CNT_W-1:0] delta;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam mode_t MODE_RST = '{dis: 1'b0, rst_en: 1'b1,
                                   delta: '1, reload: '1};

endpackage

// File: rtl/lockwd_presc.sv
// Prescaler: divides the slow-clock enable by DIV to make the count tick.
// Assumes slow_tick is a single-cycle pulse; clr restarts the division.
module lockwd_presc #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic clr,
    input  logic run,
    output logic cnt_tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    // Advance the divider on each slow pulse while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr) begin
            pcnt_q <= '0;
        end else if (slow_tick && run) begin
            pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
        end
    end

    // Count tick on the slow pulse that completes a division
    always_comb begin
        cnt_tick = slow_tick && run && !clr && (pcnt_q == LAST);
    end
endmodule

// File: rtl/lockwd_regs.sv
// Register block: decodes control, mode and status accesses, holds the
// lock and the post-restart hold-off. Assumes one access per cycle.
module lockwd_regs
    import lockwd_pkg::*;
#(
    parameter int         HOLD = 3,
    parameter logic [7:0] KEY  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              slow_tick,
    input  logic              evt_uf,
    input  logic              evt_we,
    output mode_t             mode_q,
    output logic              restart_cmd,
    output logic              lock_q,
    output logic              hold_busy,
    output logic [DATA_W-1:0] rdata
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_q;
    logic          lock_cmd;
    logic          mode_wr;
    logic          st_uf_q, st_we_q, st_rej_q;
    logic          stat_rd;

    // Command decode
    always_comb begin
        restart_cmd = wr_en && (addr == A_CTRL) && wdata[C_RESTART]
                      && (wdata[C_KEY_LSB +: 8] == KEY);
        lock_cmd    = wr_en && (addr == A_CTRL) && wdata[C_LOCK];
        mode_wr     = wr_en && (addr == A_MODE);
        stat_rd     = rd_en && (addr == A_STAT);
        hold_busy   = (hold_q != '0);
    end

    // Lock flag: set by command, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (lock_cmd) lock_q <= 1'b1;
    end

    // Hold-off counter: loads on restart, counts slow pulses down
    always_ff @(posedge clk) begin
        if (!rst_n)                      hold_q <= '0;
        else if (restart_cmd)            hold_q <= HW'(HOLD);
        else if (slow_tick && hold_busy) hold_q <= hold_q - 1'b1;
    end

    // Mode register: written when unlocked and out of hold-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (mode_wr && !lock_q && !hold_busy) begin
            mode_q.reload <= wdata[M_RELOAD_LSB +: CNT_W];
            mode_q.delta  <= wdata[M_DELTA_LSB +: CNT_W];
            mode_q.rst_en <= wdata[M_RSTEN];
            mode_q.dis    <= wdata[M_DIS];
        end
    end

    // Status bits: clear on read, a new event wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_uf_q  <= 1'b0;
            st_we_q  <= 1'b0;
            st_rej_q <= 1'b0;
        end else begin
            if (stat_rd) begin
                st_uf_q  <= 1'b0;
                st_we_q  <= 1'b0;
                st_rej_q <= 1'b0;
            end
            if (evt_uf) st_uf_q <= 1'b1;
            if (evt_we) st_we_q <= 1'b1;
            if (mode_wr && !lock_q && hold_busy) st_rej_q <= 1'b1;
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= '0;
            if (addr == A_MODE) begin
                rdata[M_RELOAD_LSB +: CNT_W] <= mode_q.reload;
                rdata[M_DELTA_LSB +: CNT_W]  <= mode_q.delta;
                rdata[M_RSTEN]               <= mode_q.rst_en;
                rdata[M_DIS]                 <= mode_q.dis;
            end else if (addr == A_STAT) begin
                rdata[S_UF]  <= st_uf_q;
                rdata[S_WE]  <= st_we_q;
                rdata[S_REJ] <= st_rej_q;
            end
        end
    end
endmodule

// File: rtl/lockwd_count.sv
// Down-counter: takes restarts, applies the reload on the next slow pulse,
// steps on count ticks and raises underflow and window-error pulses.
// Assumes restart_cmd and slow_tick are single-cycle pulses.
module lockwd_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             cnt_tick,
    input  logic             restart_cmd,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] delta,
    input  logic             dis,
    output logic             load_w,
    output logic             run,
    output logic [CNT_W-1:0] cnt_q,
    output logic             evt_uf,
    output logic             evt_we
);
    logic pend_q;
    logic exp_q;

    // Reload point and run condition
    always_comb begin
        load_w = pend_q && slow_tick && !restart_cmd;
        run    = !dis && !pend_q && !exp_q;
    end

    // Counter, pending restart, expiry and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            pend_q <= 1'b0;
            exp_q  <= 1'b0;
            evt_uf <= 1'b0;
            evt_we <= 1'b0;
        end else begin
            evt_uf <= 1'b0;
            evt_we <= 1'b0;
            if (restart_cmd) begin
                pend_q <= 1'b1;
                if (!pend_q && !exp_q && !dis && (cnt_q > delta))
                    evt_we <= 1'b1;
            end else if (load_w) begin
                cnt_q  <= reload;
                pend_q <= 1'b0;
                exp_q  <= 1'b0;
            end else if (cnt_tick) begin
                if (cnt_q == '0) begin
                    evt_uf <= 1'b1;
                    exp_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lockwd_top.sv
// Top: lockable windowed watchdog. Wires register block, prescaler and
// down-counter; forms the reset request. Assumes slow_tick is synchronous
// to clk and one cycle wide.
module lockwd_top
    import lockwd_pkg::*;
#(
    parameter int         DIV  = 128,
    parameter int         HOLD = 3,
    parameter logic [7:0] KEY  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    mode_t            mode_q;
    logic             restart_cmd;
    logic             lock_q;
    logic             hold_busy;
    logic             evt_uf, evt_we;
    logic             load_w, run, cnt_tick;
    logic [CNT_W-1:0] cnt_q;

    lockwd_regs #(.HOLD(HOLD), .KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .slow_tick(slow_tick),
        .evt_uf(evt_uf), .evt_we(evt_we), .mode_q(mode_q),
        .restart_cmd(restart_cmd), .lock_q(lock_q),
        .hold_busy(hold_busy), .rdata(rdata)
    );

    lockwd_presc #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .clr(load_w), .run(run), .cnt_tick(cnt_tick)
    );

    lockwd_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .cnt_tick(cnt_tick), .restart_cmd(restart_cmd),
        .reload(mode_q.reload), .delta(mode_q.delta), .dis(mode_q.dis),
        .load_w(load_w), .run(run), .cnt_q(cnt_q),
        .evt_uf(evt_uf), .evt_we(evt_we)
    );

    // Reset request: an event gated by the enable bit
    always_comb begin
        rst_req = (evt_uf || evt_we) && mode_q.rst_en;
    end
endmodule

// File: rtl/lockwd_chk.sv
// Checker: temporal properties of the watchdog, bound into lockwd_top.
module lockwd_chk
    import lockwd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             lock_q,
    input logic             hold_busy,
    input mode_t            mode_q,
    input logic             load_w,
    input logic [CNT_W-1:0] cnt_q,
    input logic             evt_uf
);
    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R6
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(mode_q));

    // R7
    holdoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_busy |=> $stable(mode_q));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.dis && $past(mode_q.dis)) |-> !rst_req);

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_w |=> (cnt_q <= $past(cnt_q)));

    // R4
    single_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_uf |=> !evt_uf);
endmodule

bind lockwd_top lockwd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .lock_q(lock_q),
    .hold_busy(hold_busy), .mode_q(mode_q), .load_w(load_w),
    .cnt_q(cnt_q), .evt_uf(evt_uf)
);

// File: tb/sim_lockwd_top.sv
module sim_lockwd_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    int base;
    logic [31:0] v;

    always #4 clk = ~clk;

    lockwd_top #(.DIV(DIV), .HOLD(3), .KEY(8'hA5)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    function automatic logic [31:0] mode_word(input bit dis, input bit en,
                                               input int delta, input int rl);
        return {2'b00, dis, en, 4'b0000, 12'(delta), 12'(rl)};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk) begin wr_en = 1'b1; addr = a; wdata = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk) begin rd_en = 1'b1; addr = a; end
        @(negedge clk) rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_chk(input int exp, input string req);
        idle(2);
        check(pulses == exp, req, 32'(pulses), 32'(exp));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset values
        rd(2'd2, v); check(v == 32'h0, "R1 status", v, 32'h0);
        rd(2'd1, v); check(v == 32'h10FFFFFF, "R1 mode", v, 32'h10FFFFFF);

        // R3, R4, R8: timeout sweep over reload values
        for (int r = 0; r <= 6; r++) begin
            wr(2'd1, mode_word(0, 1, 12'hFFF, r));
            rd(2'd1, v); check(v == mode_word(0, 1, 12'hFFF, r), "R3 mode write", v, mode_word(0, 1, 12'hFFF, r));
            wr(2'd0, 32'hA500_0001);
            base = pulses;
            tick(1);
            tick(2 * r + 1);
            pulse_chk(base, "R3 early");
            tick(1);
            pulse_chk(base + 1, "R3 timeout");
            rd(2'd2, v); check(v == 32'h1, "R4 underflow bit", v, 32'h1);
            rd(2'd2, v); check(v == 32'h0, "R8 cleared on read", v, 32'h0);
            tick(4);
            pulse_chk(base + 1, "R4 no repeat");
        end

        // R2: wrong keys do not restart a stopped counter
        base = pulses;
        wr(2'd0, 32'h5A00_0001);
        wr(2'd0, 32'hA400_0001);
        tick(20);
        pulse_chk(base, "R2 wrong key");
        rd(2'd2, v); check(v == 32'h0, "R2 wrong key status", v, 32'h0);
        wr(2'd0, 32'hA500_0001);
        tick(1 + 2 * 7);
        pulse_chk(base + 1, "R2 right key");
        rd(2'd2, v);

        // R5: window compare at counts 5, 4, 3, 2 with delta 3
        wr(2'd1, mode_word(0, 1, 3, 10));
        wr(2'd0, 32'hA500_0001);
        tick(1);
        for (int k = 5; k <= 8; k++) begin
            tick(2 * k);
            base = pulses;
            wr(2'd0, 32'hA500_0001);
            if (10 - k > 3) begin
                pulse_chk(base + 1, "R5 early restart pulse");
                rd(2'd2, v); check(v == 32'h2, "R5 error bit", v, 32'h2);
            end else begin
                pulse_chk(base, "R5 in-window restart");
                rd(2'd2, v); check(v == 32'h0, "R5 no error", v, 32'h0);
            end
            tick(1);
        end

        // R7: hold-off after the last restart (one slow pulse already gone)
        wr(2'd1, mode_word(0, 1, 3, 20));
        rd(2'd1, v); check(v == mode_word(0, 1, 3, 10), "R7 dropped", v, mode_word(0, 1, 3, 10));
        rd(2'd2, v); check(v == 32'h4, "R7 reject flag", v, 32'h4);
        tick(1);
        wr(2'd1, mode_word(0, 1, 3, 20));
        rd(2'd1, v); check(v == mode_word(0, 1, 3, 10), "R7 dropped late", v, mode_word(0, 1, 3, 10));
        rd(2'd2, v); check(v == 32'h4, "R7 reject flag again", v, 32'h4);
        tick(1);
        wr(2'd1, mode_word(0, 1, 3, 20));
        rd(2'd1, v); check(v == mode_word(0, 1, 3, 20), "R7 accepted", v, mode_word(0, 1, 3, 20));

        // R9: disabled counter stays quiet
        wr(2'd1, mode_word(1, 1, 12'hFFF, 2));
        base = pulses;
        wr(2'd0, 32'hA500_0001);
        tick(21);
        pulse_chk(base, "R9 no pulse");
        rd(2'd2, v); check(v == 32'h0, "R9 no status", v, 32'h0);

        // R4: reset-enable cleared gives status but no pulse
        wr(2'd1, mode_word(0, 0, 12'hFFF, 1));
        wr(2'd0, 32'hA500_0001);
        tick(1 + 4);
        pulse_chk(base, "R4 enable off");
        rd(2'd2, v); check(v == 32'h1, "R4 status with enable off", v, 32'h1);

        // R6: lock freezes mode; reset releases it
        wr(2'd0, 32'h0000_0002);
        wr(2'd1, mode_word(0, 1, 12'hFFF, 5));
        rd(2'd1, v); check(v == mode_word(0, 0, 12'hFFF, 1), "R6 locked", v, mode_word(0, 0, 12'hFFF, 1));
        rd(2'd2, v); check(v == 32'h0, "R6 no reject when locked", v, 32'h0);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd(2'd1, v); check(v == 32'h10FFFFFF, "R6 reset value", v, 32'h10FFFFFF);
        wr(2'd1, mode_word(0, 1, 12'hFFF, 5));
        rd(2'd1, v); check(v == mode_word(0, 1, 12'hFFF, 5), "R6 unlocked by reset", v, mode_word(0, 1, 12'hFFF, 5));

        // R10: total pulse count matches the events above
        check(pulses == 7 + 1 + 2, "R10 pulse total", 32'(pulses), 32'd10);

        summary();
    end
endmodule